// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block keeps the set of enabled lanes for one warp of threads while the warp runs through nested, divergent if/else code. Every lane steps through both sides of a branch. A lane commits its results only while its bit in the active mask is set, so the mask drives lane writeback enables.

Branch events arrive as commands. Each command carries an operation code and a per-lane predicate vector.

- **Push** opens a branch. The current mask is saved on an internal stack, and the new mask keeps only the lanes whose predicate is set.
- **Flip** switches to the else side. The lanes that were enabled before the branch and are not enabled now become the active set.
- **Pop** closes the branch at the reconvergence point and restores the saved mask.

The stack depth is a parameter. Misuse is recorded in a sticky error flag: pushing onto a full stack, or flipping or popping with an empty stack. A skip output is high whenever no lane is enabled, so the sequencer can jump over the path.

The command port follows valid/ready rules. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is always high, because every command completes in one cycle and back-pressure never occurs. The command's effect is visible on the outputs right after the edge that accepts it.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset, `active_mask` is all ones, `skip` is 0, `err` is 0, the stack is empty and `cmd_ready` is 1.
- R2: A push (op code 2'b01) accepted with the stack not full saves the current mask on the stack. The next mask is the old mask AND `cmd_pred`.
- R3: A flip (op code 2'b10) accepted with the stack not empty sets the mask to the top stack entry AND the inverse of the current mask. The stack is left unchanged.
- R4: A pop (op code 2'b11) accepted with the stack not empty restores the top stack entry as the mask and removes that entry.
- R5: Saved masks come back in last-in, first-out order, and the stack holds up to DEPTH of them.
- R6: A push accepted while DEPTH masks are already saved sets `err` and leaves both the mask and the stack contents unchanged.
- R7: A flip or a pop accepted with an empty stack sets `err` and leaves the mask unchanged.
- R8: `skip` is 1 exactly when `active_mask` is all zeros.
- R9: Once `err` is set, it stays set until reset.
- R10: A cycle with `cmd_valid` low, or an accepted no-op (op code 2'b00), changes neither the mask, the stack nor `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_op | input | 2 | 00 no-op, 01 push, 10 flip, 11 pop |
| cmd_pred | input | LANES | Per-lane branch predicate |
| active_mask | output | LANES | Lanes allowed to commit |
| skip | output | 1 | Active mask is empty |
| err | output | 1 | Sticky stack misuse flag |

## Verification
The hardest case to reach from the ports is the overflow push. It needs DEPTH saved masks at once, with no pop in between. A closely related case is a flip or pop deep in the nest that has to return the right saved entry after the mask has already gone to zero.

Directed sequences build the full nest on purpose, push once more, and then unwind every level. They also pop and flip on an empty stack right after reset. The random phase biases toward pushes and sparse predicates so that deep nesting and empty masks appear often. It resets at intervals so that `err` becomes observable again after each sticky error.

// File: rtl/simt_pkg.sv
package simt_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_PUSH = 2'b01,
    OP_FLIP = 2'b10,
    OP_POP  = 2'b11
  } div_op_e;
endpackage

// File: rtl/mask_lifo.sv
module mask_lifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [SW-1:0] sp;
  logic [SW-1:0] sp_dec;

  assign sp_dec = sp - 1'b1;
  assign empty  = (sp == '0);
  assign full   = (sp == SW'(DEPTH));
  assign top    = empty ? {W{1'b1}} : mem[sp_dec[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
    end else if (push && !full) begin
      sp <= sp + 1'b1;
    end else if (pop && !empty) begin
      sp <= sp_dec;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !full && sp[AW-1:0] == AW'(g)) mem[g] <= din;
    end
  end

  // R5
  lifo_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> !empty && top == $past(din));

  // R5
  lifo_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: rtl/mask_step.sv
module mask_step
  import simt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         valid,
  input  div_op_e      op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] pred,
  input  logic [W-1:0] parent,
  input  logic         empty,
  input  logic         full,
  output logic [W-1:0] nxt,
  output logic         push,
  output logic         pop,
  output logic         fault
);
  always_comb begin
    nxt   = cur;
    push  = 1'b0;
    pop   = 1'b0;
    fault = 1'b0;
    if (valid) begin
      unique case (op)
        OP_PUSH: begin
          if (full) fault = 1'b1;
          else begin
            push = 1'b1;
            nxt  = cur & pred;
          end
        end
        OP_FLIP: begin
          if (empty) fault = 1'b1;
          else nxt = parent & ~cur;
        end
        OP_POP: begin
          if (empty) fault = 1'b1;
          else begin
            pop = 1'b1;
            nxt = parent;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import simt_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [LANES-1:0] cmd_pred,
  output logic [LANES-1:0] active_mask,
  output logic             skip,
  output logic             err
);
  logic [LANES-1:0] mask_q, mask_d, parent;
  logic             st_push, st_pop, fault, st_empty, st_full, take;
  div_op_e          op;

  assign cmd_ready = 1'b1;
  assign take      = cmd_valid && cmd_ready;
  assign op        = div_op_e'(cmd_op);

  mask_lifo #(.W(LANES), .DEPTH(DEPTH)) u_lifo (
    .clk(clk), .rst_n(rst_n), .push(st_push), .pop(st_pop),
    .din(mask_q), .top(parent), .empty(st_empty), .full(st_full)
  );

  mask_step #(.W(LANES)) u_step (
    .valid(take), .op(op), .cur(mask_q), .pred(cmd_pred),
    .parent(parent), .empty(st_empty), .full(st_full),
    .nxt(mask_d), .push(st_push), .pop(st_pop), .fault(fault)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= {LANES{1'b1}};
      err    <= 1'b0;
    end else begin
      mask_q <= mask_d;
      if (fault) err <= 1'b1;
    end
  end

  assign active_mask = mask_q;
  assign skip        = ~|mask_q;

  // R2
  push_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == 2'b01 && !st_full) |=>
      (active_mask & ~$past(active_mask)) == '0);

  // R3
  flip_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == 2'b10 && !st_empty) |=>
      (active_mask & $past(active_mask)) == '0);

  // R4
  pop_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == 2'b11 && !st_empty) |=> active_mask == $past(parent));

  // R6
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == 2'b01 && st_full) |=> err && $stable(active_mask));

  // R7
  underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op[1] && st_empty) |=> err && $stable(active_mask));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || cmd_op == 2'b00) |=> $stable(active_mask));
endmodule

// File: tb/sim_simt_mask_stack.sv
module sim_simt_mask_stack;
  localparam int LANES = 32;
  localparam int DEPTH = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [1:0]       cmd_op = 2'b00;
  logic [LANES-1:0] cmd_pred = '0;
  logic [LANES-1:0] active_mask;
  logic             skip;
  logic             err;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  logic [LANES-1:0] m_mask;
  logic [LANES-1:0] m_stk [DEPTH];
  int               m_sp;
  logic             m_err;

  always #2 clk = ~clk;

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_pred(cmd_pred), .active_mask(active_mask),
    .skip(skip), .err(err)
  );

  function automatic void model_step(bit v, logic [1:0] op, logic [LANES-1:0] p);
    if (!v) return;
    case (op)
      2'b01: if (m_sp == DEPTH) m_err = 1'b1;
             else begin m_stk[m_sp] = m_mask; m_sp++; m_mask = m_mask & p; end
      2'b10: if (m_sp == 0) m_err = 1'b1;
             else m_mask = m_stk[m_sp-1] & ~m_mask;
      2'b11: if (m_sp == 0) m_err = 1'b1;
             else begin m_sp--; m_mask = m_stk[m_sp]; end
      default: ;
    endcase
  endfunction

  task automatic compare(string req);
    vectors++;
    if (active_mask !== m_mask) begin
      misses++;
      $display("FAIL %s mask actual=%h expected=%h", req, active_mask, m_mask);
    end
    if (skip !== (m_mask == '0)) begin
      misses++;
      $display("FAIL R8 (%s) skip actual=%b expected=%b", req, skip, m_mask == '0);
    end
    if (err !== m_err) begin
      misses++;
      $display("FAIL %s err actual=%b expected=%b", req, err, m_err);
    end
    if (cmd_ready !== 1'b1) begin
      misses++;
      $display("FAIL %s cmd_ready actual=%b expected=1", req, cmd_ready);
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    m_mask = '1; m_sp = 0; m_err = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
  endtask

  task automatic apply(bit v, logic [1:0] op, logic [LANES-1:0] p, string req);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_pred = p;
    @(posedge clk); #1;
    model_step(v, op, p);
    compare(req);
    cmd_valid = 1'b0;
  endtask

  initial begin
    logic [LANES-1:0] p;
    logic [1:0]       op;
    void'($urandom(32'd2024));
    do_reset();
    // Pop and flip on an empty stack
    apply(1, 2'b11, '0, "R7");
    apply(1, 2'b10, '0, "R7");
    apply(1, 2'b00, 32'h1234_5678, "R9");
    do_reset();
    // Nested if/else
    apply(1, 2'b01, 32'h0000_FFFF, "R2");
    apply(1, 2'b01, 32'h00FF_00FF, "R2");
    apply(1, 2'b10, '0, "R3");
    apply(0, 2'b01, 32'h0, "R10");
    apply(1, 2'b00, 32'h0, "R10");
    apply(1, 2'b11, '0, "R4");
    apply(1, 2'b10, '0, "R3");
    apply(1, 2'b11, '0, "R4");
    // Mask goes empty
    apply(1, 2'b01, 32'h0, "R8");
    apply(1, 2'b10, '0, "R3");
    apply(1, 2'b11, '0, "R4");
    // Fill the stack, overflow, then unwind
    for (int i = 0; i < DEPTH; i++) apply(1, 2'b01, ~(32'h1 << i), "R5");
    apply(1, 2'b01, 32'h0, "R6");
    for (int i = 0; i < DEPTH; i++) apply(1, 2'b11, '0, "R5");
    apply(1, 2'b11, '0, "R7");
    // Random phase
    for (int n = 0; n < 3000; n++) begin
      if (n % 150 == 0) do_reset();
      case ($urandom % 8)
        0, 1, 2: op = 2'b01;
        3, 4:    op = 2'b10;
        5, 6:    op = 2'b11;
        default: op = 2'b00;
      endcase
      case ($urandom % 4)
        0:       p = '0;
        1:       p = $urandom & $urandom;
        default: p = $urandom;
      endcase
      apply(($urandom % 10) != 0, op, p, "R5");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule